// File: doc/BRIEF.md
# SMO Working-Pair Selector

This unit performs the pair-selection step of one sequential-minimal-optimization training iteration. A pulse on `start` begins the pass. On that pulse the unit latches the sample count, the box bound C and the stopping tolerance. It then reads every stored training sample in ascending order. Each sample has three fields: a one-bit class label, a multiplier and an error term.

Each sample is sorted into the "up" candidate set, the "low" candidate set, or both. The sorting depends on the label and on where the multiplier sits relative to 0 and C. While it scans, the unit keeps the up-set sample with the largest error term and the low-set sample with the smallest one.

When the pass ends it publishes both indices, both error terms and a convergence verdict, and pulses `done`. Every value is a signed 24-bit fixed-point number with 18 fraction bits. Before training begins, every multiplier is 0 and every error term equals ±1.0 according to the label.

The sample store is an external synchronous RAM with one cycle of read latency. It is addressed through a plain read-enable/address port, so there is no streaming handshake and no back-pressure. Optimizing the pair and updating the error terms belong to neighbouring blocks.

Top module: `smo_pair_select`

## Requirements
- R1: A sample is an up-set member when its multiplier is below C with label bit 1 (class +1), or when its multiplier is above 0 with label bit 0 (class −1). All comparisons are signed.
- R2: A sample is a low-set member when its multiplier is below C with label bit 0, or when its multiplier is above 0 with label bit 1.
- R3: `idx_up` and `f_up` report the up-set member with the greatest error term. On a tie, the lowest index wins. These outputs change only in the cycle where `done` is high.
- R4: `idx_low` and `f_low` report the low-set member with the smallest error term. On a tie, the lowest index wins.
- R5: When both sets are non-empty, `converged` is 1 exactly when `f_up − f_low` is less than the latched tolerance. The difference is computed without overflow.
- R6: When either set is empty, or the sample count is 0, `converged` is 1 and the four index and error outputs keep their previous values.
- R7: `done` is a one-cycle pulse that rises 5·m+1 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until `done` rises, and it is low while `done` is high.
- R8: The sample count, C and the tolerance are latched when `start` is accepted. Changing those inputs during a pass does not change its results or its length.
- R9: In each pass, sample addresses 0 to m−1 are each read exactly once, in ascending order. A read is issued at most once every five cycles, and only while `busy` is high.
- R10: After reset, `busy`, `done`, `converged`, `mem_rd_en`, both indices and both error outputs are 0.
- R11: A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a selection pass (accepted when not busy) |
| num_samples | input | CNT_W | Number of samples m to scan |
| c_bound | input | 24 | Upper multiplier bound C, signed fixed point |
| tolerance | input | 24 | Convergence tolerance, signed fixed point |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| converged | output | 1 | Training-finished verdict for this pass |
| idx_up | output | IDX_W | Index of the chosen up-set sample |
| idx_low | output | IDX_W | Index of the chosen low-set sample |
| f_up | output | 24 | Error term of `idx_up` |
| f_low | output | 24 | Error term of `idx_low` |
| mem_rd_en | output | 1 | Sample RAM read strobe |
| mem_addr | output | IDX_W | Sample RAM read address |
| mem_label | input | 1 | Label bit returned by the RAM (1 = +1) |
| mem_alpha | input | 24 | Multiplier returned by the RAM |
| mem_err | input | 24 | Error term returned by the RAM |

## Verification
Every result is due at one cycle only. The bench raises `start` on a falling edge and counts falling edges until `done` is seen, and that count must equal 5·m+1. Indices, error terms and the verdict are sampled in that same half-cycle, and `done` is then checked to be low one edge later.

The RAM model answers one edge after each strobe. A falling-edge monitor checks the address sequence while the pass runs. Inputs that must be ignored are changed a few cycles into a pass, and the results at `done` must still match the values predicted from the latched settings.

// File: rtl/smo_sel_pkg.sv
package smo_sel_pkg;
  localparam int FIX_W         = 24;
  localparam int FRAC_W        = 18;
  localparam int SAMPLE_CYCLES = 5;

  typedef logic signed [FIX_W-1:0] fix_t;

  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_SCAN = 2'd1,
    SEL_FIN  = 2'd2
  } sel_state_e;
endpackage

// File: rtl/smo_set_classify.sv
module smo_set_classify
  import smo_sel_pkg::*;
(
  input  logic label_pos,
  input  fix_t alpha,
  input  fix_t c_bound,
  output logic in_up,
  output logic in_low
);
  logic below_c, above_zero;

  always_comb begin
    below_c    = alpha < c_bound;
    above_zero = alpha > '0;
    in_up      = (below_c && label_pos) || (above_zero && !label_pos);
    in_low     = (below_c && !label_pos) || (above_zero && label_pos);
  end
endmodule

// File: rtl/smo_extreme_track.sv
module smo_extreme_track
  import smo_sel_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter bit FIND_MAX = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample_en,
  input  logic [IDX_W-1:0] cand_idx,
  input  fix_t             cand_val,
  output logic             found,
  output logic [IDX_W-1:0] best_idx,
  output fix_t             best_val
);
  logic beats;

  generate
    if (FIND_MAX) begin : g_max
      assign beats = cand_val > best_val;
    end else begin : g_min
      assign beats = cand_val < best_val;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found    <= 1'b0;
      best_idx <= '0;
      best_val <= '0;
    end else if (clear) begin
      found <= 1'b0;
    end else if (sample_en && (!found || beats)) begin
      found    <= 1'b1;
      best_idx <= cand_idx;
      best_val <= cand_val;
    end
  end
endmodule

// File: rtl/smo_pair_select.sv
module smo_pair_select
  import smo_sel_pkg::*;
#(
  parameter  int MAX_SAMPLES = 1024,
  localparam int IDX_W       = $clog2(MAX_SAMPLES),
  localparam int CNT_W       = $clog2(MAX_SAMPLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CNT_W-1:0]        num_samples,
  input  logic signed [FIX_W-1:0] c_bound,
  input  logic signed [FIX_W-1:0] tolerance,
  output logic                    busy,
  output logic                    done,
  output logic                    converged,
  output logic [IDX_W-1:0]        idx_up,
  output logic [IDX_W-1:0]        idx_low,
  output logic signed [FIX_W-1:0] f_up,
  output logic signed [FIX_W-1:0] f_low,
  output logic                    mem_rd_en,
  output logic [IDX_W-1:0]        mem_addr,
  input  logic                    mem_label,
  input  logic signed [FIX_W-1:0] mem_alpha,
  input  logic signed [FIX_W-1:0] mem_err
);
  localparam logic [2:0] PH_CAPT  = 3'd1;
  localparam logic [2:0] PH_CLASS = 3'd2;
  localparam logic [2:0] PH_TRACK = 3'd3;
  localparam logic [2:0] PH_LAST  = 3'(SAMPLE_CYCLES - 1);

  sel_state_e       state;
  logic [2:0]       ph;
  logic [CNT_W-1:0] k, m_q;
  fix_t             c_q, eps_q, alpha_q, err_q;
  logic             lab_q, up_hit_q, low_hit_q;
  logic             cls_up, cls_low;
  logic             accept, trk_up_en, trk_low_en;
  logic             up_found, low_found;
  logic [IDX_W-1:0] up_idx_w, low_idx_w;
  fix_t             up_val_w, low_val_w;
  logic signed [FIX_W:0] gap_w, eps_w;

  assign accept     = (state == SEL_IDLE) && start;
  assign busy       = (state != SEL_IDLE);
  assign mem_rd_en  = (state == SEL_SCAN) && (ph == 3'd0);
  assign mem_addr   = k[IDX_W-1:0];
  assign trk_up_en  = (state == SEL_SCAN) && (ph == PH_TRACK) && up_hit_q;
  assign trk_low_en = (state == SEL_SCAN) && (ph == PH_TRACK) && low_hit_q;
  assign gap_w = $signed({up_val_w[FIX_W-1], up_val_w}) - $signed({low_val_w[FIX_W-1], low_val_w});
  assign eps_w = $signed({eps_q[FIX_W-1], eps_q});

  smo_set_classify u_classify (
    .label_pos (lab_q),
    .alpha     (alpha_q),
    .c_bound   (c_q),
    .in_up     (cls_up),
    .in_low    (cls_low)
  );

  smo_extreme_track #(.IDX_W(IDX_W), .FIND_MAX(1'b1)) u_track_up (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .sample_en (trk_up_en),
    .cand_idx  (k[IDX_W-1:0]),
    .cand_val  (err_q),
    .found     (up_found),
    .best_idx  (up_idx_w),
    .best_val  (up_val_w)
  );

  smo_extreme_track #(.IDX_W(IDX_W), .FIND_MAX(1'b0)) u_track_low (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .sample_en (trk_low_en),
    .cand_idx  (k[IDX_W-1:0]),
    .cand_val  (err_q),
    .found     (low_found),
    .best_idx  (low_idx_w),
    .best_val  (low_val_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEL_IDLE;
      ph        <= '0;
      k         <= '0;
      m_q       <= '0;
      c_q       <= '0;
      eps_q     <= '0;
      lab_q     <= 1'b0;
      alpha_q   <= '0;
      err_q     <= '0;
      up_hit_q  <= 1'b0;
      low_hit_q <= 1'b0;
      done      <= 1'b0;
      converged <= 1'b0;
      idx_up    <= '0;
      idx_low   <= '0;
      f_up      <= '0;
      f_low     <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEL_IDLE: begin
          if (start) begin
            m_q   <= num_samples;
            c_q   <= c_bound;
            eps_q <= tolerance;
            k     <= '0;
            ph    <= '0;
            state <= (num_samples == '0) ? SEL_FIN : SEL_SCAN;
          end
        end
        SEL_SCAN: begin
          if (ph == PH_CAPT) begin
            lab_q   <= mem_label;
            alpha_q <= mem_alpha;
            err_q   <= mem_err;
          end
          if (ph == PH_CLASS) begin
            up_hit_q  <= cls_up;
            low_hit_q <= cls_low;
          end
          if (ph == PH_LAST) begin
            ph <= '0;
            if (k == m_q - 1'b1) state <= SEL_FIN;
            else                 k     <= k + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        SEL_FIN: begin
          state <= SEL_IDLE;
          done  <= 1'b1;
          if (up_found && low_found) begin
            idx_up    <= up_idx_w;
            idx_low   <= low_idx_w;
            f_up      <= up_val_w;
            f_low     <= low_val_w;
            converged <= gap_w < eps_w;
          end else begin
            converged <= 1'b1;
          end
        end
        default: state <= SEL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smo_pair_select_chk.sv
module smo_pair_select_chk
  import smo_sel_pkg::*;
#(
  parameter  int MAX_SAMPLES = 1024,
  localparam int IDX_W       = $clog2(MAX_SAMPLES),
  localparam int CNT_W       = $clog2(MAX_SAMPLES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [CNT_W-1:0]        num_samples,
  input logic signed [FIX_W-1:0] tolerance,
  input logic                    busy,
  input logic                    done,
  input logic                    converged,
  input logic [IDX_W-1:0]        idx_up,
  input logic signed [FIX_W-1:0] f_up,
  input logic signed [FIX_W-1:0] f_low,
  input logic                    mem_rd_en,
  input logic [IDX_W-1:0]        mem_addr
);
  int unsigned      lat_cnt;
  logic [CNT_W-1:0] m_cap;
  logic [CNT_W-1:0] next_addr;
  fix_t             eps_cap;
  logic signed [FIX_W:0] gap_obs;

  assign gap_obs = $signed({f_up[FIX_W-1], f_up}) - $signed({f_low[FIX_W-1], f_low});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt   <= '0;
      m_cap     <= '0;
      next_addr <= '0;
      eps_cap   <= '0;
    end else if (start && !busy) begin
      lat_cnt   <= '0;
      m_cap     <= num_samples;
      next_addr <= '0;
      eps_cap   <= tolerance;
    end else begin
      if (lat_cnt != 32'hFFFF_FFFF) lat_cnt <= lat_cnt + 1'b1;
      if (mem_rd_en) next_addr <= next_addr + 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (lat_cnt == 5 * int'(m_cap) + 1)); // R7
  AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |=> !mem_rd_en); // R9
  AST_RD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |-> busy); // R9
  AST_RD_ORDER: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |-> (mem_addr == next_addr[IDX_W-1:0] && next_addr < m_cap)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (idx_up != $past(idx_up)) |-> done); // R3
  AST_GAP_RULE: assert property (@(posedge clk) disable iff (!rst_n) (done && !converged) |-> gap_obs >= $signed({eps_cap[FIX_W-1], eps_cap})); // R5
endmodule

bind smo_pair_select smo_pair_select_chk #(.MAX_SAMPLES(MAX_SAMPLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .num_samples (num_samples),
  .tolerance   (tolerance),
  .busy        (busy),
  .done        (done),
  .converged   (converged),
  .idx_up      (idx_up),
  .f_up        (f_up),
  .f_low       (f_low),
  .mem_rd_en   (mem_rd_en),
  .mem_addr    (mem_addr)
);

// File: tb/smo_pair_select_tb.sv
module smo_pair_select_tb;
  localparam int MAXS = 16;
  localparam int IW   = 4;
  localparam int CW   = 5;
  localparam int FW   = 24;
  localparam logic signed [FW-1:0] ONE = 24'sd262144;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, busy, done, converged, mem_rd_en, mem_label;
  logic [CW-1:0] num_samples;
  logic signed [FW-1:0] c_bound, tolerance, f_up, f_low, mem_alpha, mem_err;
  logic [IW-1:0] idx_up, idx_low, mem_addr;

  logic                 ram_y [MAXS];
  logic signed [FW-1:0] ram_a [MAXS];
  logic signed [FW-1:0] ram_f [MAXS];

  smo_pair_select #(.MAX_SAMPLES(MAXS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_samples(num_samples),
    .c_bound(c_bound), .tolerance(tolerance), .busy(busy), .done(done),
    .converged(converged), .idx_up(idx_up), .idx_low(idx_low),
    .f_up(f_up), .f_low(f_low), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_label(mem_label), .mem_alpha(mem_alpha), .mem_err(mem_err)
  );

  always_ff @(posedge clk) begin
    if (mem_rd_en) begin
      mem_label <= ram_y[mem_addr];
      mem_alpha <= ram_a[mem_addr];
      mem_err   <= ram_f[mem_addr];
    end
  end

  int n_checks = 0;
  int n_fail   = 0;
  int rd_seen  = 0;
  bit rd_bad   = 1'b0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  // R9 read-order monitor
  always @(negedge clk) begin
    if (mem_rd_en) begin
      if (int'(mem_addr) != rd_seen) rd_bad = 1'b1;
      rd_seen = rd_seen + 1;
    end
  end

  // expected outputs, persisting across passes (R6)
  int                   e_iu = 0, e_il = 0;
  logic signed [FW-1:0] e_fu = '0, e_fl = '0;
  bit                   e_conv = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd_step(input logic [31:0] s);
    logic [31:0] r;
    r = s ^ (s << 13);
    r = r ^ (r >> 17);
    r = r ^ (r << 5);
    return r;
  endfunction

  task automatic fill_random(input int m, input logic signed [FW-1:0] c);
    for (int i = 0; i < m; i++) begin
      int v;
      lfsr = rnd_step(lfsr);
      ram_y[i] = lfsr[0];
      case (lfsr[3:2])
        2'd0: ram_a[i] = '0;
        2'd1: ram_a[i] = c;
        2'd2: ram_a[i] = c >>> 1;
        default: ram_a[i] = lfsr[4] ? c : '0;
      endcase
      v = int'(lfsr[10:8]) - 4;
      ram_f[i] = FW'(v * 65536 + int'(lfsr[13:12]));
    end
  endtask

  task automatic run_case(input string name, input int m, input logic signed [FW-1:0] c,
                          input logic signed [FW-1:0] eps, input bit perturb, input bit restart);
    bit fu = 0, fl = 0;
    int bu_i = 0, bl_i = 0, cnt;
    logic signed [FW-1:0] bu = '0, bl = '0;
    logic signed [FW:0] gap;
    for (int i = 0; i < m; i++) begin
      bit up, low;
      up  = (ram_a[i] < c && ram_y[i]) || (ram_a[i] > 0 && !ram_y[i]);   // R1
      low = (ram_a[i] < c && !ram_y[i]) || (ram_a[i] > 0 && ram_y[i]);   // R2
      if (up && (!fu || ram_f[i] > bu)) begin fu = 1; bu = ram_f[i]; bu_i = i; end
      if (low && (!fl || ram_f[i] < bl)) begin fl = 1; bl = ram_f[i]; bl_i = i; end
    end
    if (fu && fl) begin
      e_iu = bu_i; e_il = bl_i; e_fu = bu; e_fl = bl;
      gap = $signed({bu[FW-1], bu}) - $signed({bl[FW-1], bl});
      e_conv = gap < $signed({eps[FW-1], eps});
    end else begin
      e_conv = 1'b1;
    end

    @(negedge clk);
    num_samples = CW'(m); c_bound = c; tolerance = eps; start = 1'b1;
    rd_seen = 0; rd_bad = 1'b0;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 400) begin
      @(negedge clk);
      cnt++;
      if (perturb && cnt == 2) begin
        num_samples = CW'(MAXS); c_bound = -c; tolerance = 24'sh7FFFFF;
      end
      if (restart && cnt == 7) start = 1'b1;
      if (restart && cnt == 8) start = 1'b0;
    end
    check(cnt == 5 * m + 1, {name, " R7 latency"}, cnt, 5 * m + 1);
    check(int'(idx_up) == e_iu, {name, " R1 R3 idx_up"}, idx_up, e_iu);
    check(f_up == e_fu, {name, " R3 f_up"}, f_up, e_fu);
    check(int'(idx_low) == e_il, {name, " R2 R4 idx_low"}, idx_low, e_il);
    check(f_low == e_fl, {name, " R4 f_low"}, f_low, e_fl);
    check(converged == e_conv, {name, " R5 R6 converged"}, converged, e_conv);
    check(rd_seen == m && !rd_bad, {name, " R9 reads"}, rd_seen, m);
    @(negedge clk);
    check(!done, {name, " R7 done pulse"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; num_samples = '0; c_bound = '0; tolerance = '0;
    for (int i = 0; i < MAXS; i++) begin ram_y[i] = 1'b0; ram_a[i] = '0; ram_f[i] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !converged && !mem_rd_en, "R10 reset flags",
          {busy, done, converged, mem_rd_en}, 0);
    check(idx_up == '0 && idx_low == '0 && f_up == '0 && f_low == '0, "R10 reset values",
          f_up, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // initial training state: alpha = 0, F = label as +-1.0
    for (int i = 0; i < 8; i++) begin
      ram_y[i] = (i % 3) != 0;
      ram_a[i] = '0;
      ram_f[i] = ram_y[i] ? ONE : -ONE;
    end
    run_case("init", 8, ONE, 24'sd262, 1'b0, 1'b0);

    // sweep over sample count and settings
    for (int m = 0; m <= MAXS; m++) begin
      for (int v = 0; v < 4; v++) begin
        logic signed [FW-1:0] c, eps;
        c = v[0] ? 10 * ONE : ONE;
        case (v)
          0: eps = '0;
          1: eps = 24'sd262;
          2: eps = ONE;
          default: eps = 3 * ONE;
        endcase
        fill_random(m, c);
        run_case("sweep", m, c, eps, 1'b0, 1'b0);
      end
    end

    // R6 empty up set
    for (int i = 0; i < 5; i++) begin ram_y[i] = 1'b1; ram_a[i] = ONE; ram_f[i] = FW'(i); end
    run_case("R6 empty-up", 5, ONE, '0, 1'b0, 1'b0);
    // R6 empty low set
    for (int i = 0; i < 5; i++) begin ram_y[i] = 1'b0; ram_a[i] = ONE; ram_f[i] = -FW'(i); end
    run_case("R6 empty-low", 5, ONE, '0, 1'b0, 1'b0);

    // ties: every F equal, lowest index wins (R3, R4)
    for (int i = 0; i < MAXS; i++) begin ram_y[i] = i[0]; ram_a[i] = ONE >>> 1; ram_f[i] = ONE; end
    run_case("R3 R4 ties", MAXS, ONE, '0, 1'b0, 1'b0);

    // R8 inputs changed mid-pass
    fill_random(6, 2 * ONE);
    run_case("R8 latch", 6, 2 * ONE, 24'sd262, 1'b1, 1'b0);

    // R11 start while busy
    fill_random(5, ONE);
    run_case("R11 restart", 5, ONE, ONE, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule